// File: doc/BRIEF.md
# Cascaded Programmable Display Sync Generator

This block produces display timing (horizontal and vertical sync, field markers, active-line and active-pixel strobes) from a bank of identical programmable counters rather than from fixed horizontal and vertical counters. Each counter advances on ticks from a source it selects. A source is either every clock (the pixel clock) or the one-cycle output pulse of another counter. Chaining counters this way builds line counters from pixel counters, frame counters from line counters, and so on.

Each counter has four parts. A start offset delays its first pulse. A run length sets its period. A repeat limit can stop it after a fixed number of pulses. A clear source lets another counter's pulse restart it. A counter can also drive a waveform output whose rising and falling points are given in half-tick units and counted on a selectable trigger source. Each waveform output can be inverted. Software fills a shadow copy of the settings through a write port. The settings become active when the global run enable rises, and at that moment every counter starts in the same clock.

Top module: `sync_timing_array`

## Requirements
- R1: With run and offset sources set to 1 (every clock), offset N and run length R, a counter's bit of `pulse_o` is high for one cycle after the (N+1)-th clock edge that follows the edge at which `run_en` is first sampled high. After that it pulses every R+1 clocks.
- R2: Source select codes are 0 = no ticks ever, 1 = a tick every clock, and n >= 2 = the pulse of counter n-1 (counters numbered 1..NCNT, i.e. bit n-2 of `pulse_o`) as registered on the previous clock. A counter clocked by another therefore pulses one cycle after the pulse that advanced it.
- R3: The offset is counted in ticks of the counter's own offset source. An offset of 0 lets the first run tick after start or clear produce a pulse.
- R4: A non-zero repeat count K yields exactly K pulses, after which the counter stays silent until it is restarted. A repeat count of 0 lets it run freely.
- R5: A tick on a counter's clear source restarts it: offset, period phase and repeat tally all begin again. A run tick in the same clock is dropped.
- R6: With waveform enabled, the waveform output goes low at start or clear. On the counter's own pulse, the trigger-tick tally restarts at 0. The output rises when the tally equals ceil(up/2) and falls when it equals ceil(down/2). A rise takes priority when the two match together. A disabled waveform stays low.
- R7: Each `wave_o` bit is the waveform level XOR its polarity bit. This also holds while the block is idle.
- R8: Writes change only the shadow settings. The active settings, including polarity, are replaced from the shadow only at the clock where `run_en` rises.
- R9: While `run_en` is low every counter is idle, `pulse_o` is all zero and waveform levels are low. At the rising edge of `run_en` all counters start together, with no pulse in that cycle.
- R10: Address bit 5 = 0 selects counter `addr[4:2]`. Word `addr[1:0]` = 0 holds run length [11:0], offset [23:12], run source [27:24] and offset source [31:28]. Word 1 holds repeat count [11:0], clear source [15:12], trigger source [19:16] and waveform enable [20]. Word 2 holds up position [9:0] and down position [25:16]. Address 6'b100000 holds the polarity bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Global enable; its rise loads settings and starts all counters |
| cfg_we | input | 1 | Write strobe for the shadow settings |
| cfg_addr | input | $clog2(NCNT)+3 | Write address (6 bits by default) |
| cfg_wdata | input | 32 | Write data |
| pulse_o | output | NCNT | One-cycle pulse of each counter |
| wave_o | output | NCNT | Waveform output of each counter after polarity |

## Verification
Random single-counter trials vary the offset, period, repeat limit and waveform edge positions together. This separates off-by-one errors in the offset from errors in the period, and shows when the repeat limit stops the counter. Directed runs cover the cases random trials reach only by chance. A chained pair shows the one-cycle source delay and the behaviour of source code 0. A clear-driven pair shows that a clear wins over a run tick in the same clock. An odd down position shows half-tick round-up, and polarity writes made while idle show that settings take effect only when `run_en` rises. A mid-run write of a new period checks that the active settings stay frozen until the restart.

// File: rtl/syncgen_pkg.sv
`timescale 1ns/1ps
package syncgen_pkg;
    localparam int CNT_W  = 12;   // run, offset and repeat counts
    localparam int POS_W  = 10;   // waveform edge positions (half ticks)
    localparam int SRC_W  = 4;    // source select codes
    localparam int DATA_W = 32;   // write data width

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_OFS  = 2'd1,
        PH_RUN  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SRC_W-1:0] run_src;
        logic [SRC_W-1:0] ofs_src;
        logic [SRC_W-1:0] clr_src;
        logic [SRC_W-1:0] trig_src;
        logic [CNT_W-1:0] run_len;
        logic [CNT_W-1:0] ofs_len;
        logic [CNT_W-1:0] rep_cnt;
        logic             wave_en;
        logic [POS_W-1:0] up_pos;
        logic [POS_W-1:0] down_pos;
    } chan_cfg_t;
endpackage

// File: rtl/stg_cfg_bank.sv
`timescale 1ns/1ps
module stg_cfg_bank
    import syncgen_pkg::*;
#(
    parameter int NCNT = 8,
    localparam int IW = $clog2(NCNT),
    localparam int ADDR_W = IW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              start,
    output chan_cfg_t         cfg_o [NCNT],
    output logic [NCNT-1:0]   pol_o
);
    typedef struct packed {
        chan_cfg_t [NCNT-1:0] shd;
        chan_cfg_t [NCNT-1:0] act;
        logic [NCNT-1:0]      pol_shd;
        logic [NCNT-1:0]      pol_act;
    } bank_t;

    bank_t st_d, st_q;
    logic [IW-1:0] widx;

    always_comb begin
        st_d = st_q;
        widx = cfg_addr[IW+1:2];
        if (cfg_we) begin
            if (cfg_addr[ADDR_W-1]) begin
                if (cfg_addr[ADDR_W-2:0] == '0)
                    st_d.pol_shd = cfg_wdata[NCNT-1:0];
            end else if (int'(widx) < NCNT) begin
                case (cfg_addr[1:0])
                    2'd0: begin
                        st_d.shd[widx].run_len = cfg_wdata[11:0];
                        st_d.shd[widx].ofs_len = cfg_wdata[23:12];
                        st_d.shd[widx].run_src = cfg_wdata[27:24];
                        st_d.shd[widx].ofs_src = cfg_wdata[31:28];
                    end
                    2'd1: begin
                        st_d.shd[widx].rep_cnt  = cfg_wdata[11:0];
                        st_d.shd[widx].clr_src  = cfg_wdata[15:12];
                        st_d.shd[widx].trig_src = cfg_wdata[19:16];
                        st_d.shd[widx].wave_en  = cfg_wdata[20];
                    end
                    2'd2: begin
                        st_d.shd[widx].up_pos   = cfg_wdata[9:0];
                        st_d.shd[widx].down_pos = cfg_wdata[25:16];
                    end
                    default: ;
                endcase
            end
        end
        // shadow becomes active only when the run enable rises
        if (start) begin
            st_d.act     = st_q.shd;
            st_d.pol_act = st_q.pol_shd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NCNT; k++) begin : g_out
        assign cfg_o[k] = start ? st_q.shd[k] : st_q.act[k];
    end
    assign pol_o = st_q.pol_act;
endmodule

// File: rtl/stg_counter.sv
`timescale 1ns/1ps
module stg_counter
    import syncgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] ofs_len,
    input  logic [CNT_W-1:0] rep_cnt,
    input  logic             run_tick,
    input  logic             ofs_tick,
    input  logic             clr_tick,
    output logic             fire,
    output logic             restart,
    output logic             pulse_q
);
    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reps;
        logic             pulse;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        restart    = 1'b0;
        if (!run) begin
            st_d.ph   = PH_IDLE;
            st_d.cnt  = '0;
            st_d.reps = '0;
        end else if (start || clr_tick) begin
            // restart dominates any tick in the same clock
            restart   = 1'b1;
            st_d.reps = '0;
            if (ofs_len == '0) begin
                st_d.ph  = PH_RUN;
                st_d.cnt = '0;
            end else begin
                st_d.ph  = PH_OFS;
                st_d.cnt = ofs_len;
            end
        end else begin
            case (st_q.ph)
                PH_OFS: begin
                    if (ofs_tick) begin
                        if (st_q.cnt == CNT_W'(1)) begin
                            st_d.ph  = PH_RUN;
                            st_d.cnt = '0;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_W'(1);
                        end
                    end
                end
                PH_RUN: begin
                    if (run_tick) begin
                        if (st_q.cnt == '0) begin
                            st_d.pulse = 1'b1;
                            st_d.cnt   = run_len;
                            st_d.reps  = st_q.reps + CNT_W'(1);
                            if (rep_cnt != '0 && (st_q.reps + CNT_W'(1)) == rep_cnt)
                                st_d.ph = PH_DONE;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire    = st_d.pulse;
    assign pulse_q = st_q.pulse;
endmodule

// File: rtl/stg_wave.sv
`timescale 1ns/1ps
module stg_wave
    import syncgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wave_en,
    input  logic [POS_W-1:0] up_pos,
    input  logic [POS_W-1:0] down_pos,
    input  logic             restart,
    input  logic             fire,
    input  logic             trig_tick,
    output logic             lvl_q
);
    localparam logic [POS_W-1:0] TMAX = '1;

    typedef struct packed {
        logic [POS_W-1:0] tcnt;
        logic             lvl;
    } wv_st_t;

    wv_st_t st_d, st_q;
    logic [POS_W:0]   up_sum, dn_sum;
    logic [POS_W-1:0] up_h, dn_h, nxt;

    always_comb begin
        // half-tick positions round up to the next whole tick
        up_sum = {1'b0, up_pos} + (POS_W+1)'(1);
        dn_sum = {1'b0, down_pos} + (POS_W+1)'(1);
        up_h   = up_sum[POS_W:1];
        dn_h   = dn_sum[POS_W:1];
        nxt    = (st_q.tcnt == TMAX) ? TMAX : st_q.tcnt + POS_W'(1);
        st_d   = st_q;
        if (!run || !wave_en || restart) begin
            st_d.tcnt = TMAX;
            st_d.lvl  = 1'b0;
        end else if (fire) begin
            st_d.tcnt = '0;
            if (up_h == '0)      st_d.lvl = 1'b1;
            else if (dn_h == '0) st_d.lvl = 1'b0;
        end else if (trig_tick) begin
            st_d.tcnt = nxt;
            if (nxt == up_h)      st_d.lvl = 1'b1;
            else if (nxt == dn_h) st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tcnt: TMAX, lvl: 1'b0};
        else        st_q <= st_d;
    end

    assign lvl_q = st_q.lvl;
endmodule

// File: rtl/sync_timing_array.sv
`timescale 1ns/1ps
module sync_timing_array
    import syncgen_pkg::*;
#(
    parameter int NCNT = 8,
    localparam int ADDR_W = $clog2(NCNT) + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [NCNT-1:0]   pulse_o,
    output logic [NCNT-1:0]   wave_o
);
    localparam int NSRC = NCNT + 2;

    typedef struct packed {
        logic run;
    } top_st_t;

    top_st_t st_d, st_q;
    logic start;
    chan_cfg_t cfg_eff [NCNT];
    logic [NCNT-1:0] pol_act;
    logic [NCNT-1:0] pulse_v, fire_v, restart_v, wave_lvl;
    logic [NCNT-1:0] run_tk, ofs_tk, clr_tk, trig_tk;
    logic [NSRC-1:0] src_v;

    // code 0: never, code 1: every clock, code n: registered pulse of counter n-1
    function automatic logic pick(input logic [SRC_W-1:0] sel, input logic [NSRC-1:0] v);
        if (int'(sel) < NSRC) return v[sel];
        return 1'b0;
    endfunction

    always_comb begin
        st_d.run = run_en;
        start    = run_en & ~st_q.run;
        src_v    = {pulse_v, 1'b1, 1'b0};
        pulse_o  = pulse_v;
        wave_o   = wave_lvl ^ pol_act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    stg_cfg_bank #(.NCNT(NCNT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .start     (start),
        .cfg_o     (cfg_eff),
        .pol_o     (pol_act)
    );

    for (genvar k = 0; k < NCNT; k++) begin : g_chan
        assign run_tk[k]  = pick(cfg_eff[k].run_src,  src_v);
        assign ofs_tk[k]  = pick(cfg_eff[k].ofs_src,  src_v);
        assign clr_tk[k]  = pick(cfg_eff[k].clr_src,  src_v);
        assign trig_tk[k] = pick(cfg_eff[k].trig_src, src_v);

        stg_counter u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_en),
            .start    (start),
            .run_len  (cfg_eff[k].run_len),
            .ofs_len  (cfg_eff[k].ofs_len),
            .rep_cnt  (cfg_eff[k].rep_cnt),
            .run_tick (run_tk[k]),
            .ofs_tick (ofs_tk[k]),
            .clr_tick (clr_tk[k]),
            .fire     (fire_v[k]),
            .restart  (restart_v[k]),
            .pulse_q  (pulse_v[k])
        );

        stg_wave u_wave (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run_en),
            .wave_en   (cfg_eff[k].wave_en),
            .up_pos    (cfg_eff[k].up_pos),
            .down_pos  (cfg_eff[k].down_pos),
            .restart   (restart_v[k]),
            .fire      (fire_v[k]),
            .trig_tick (trig_tk[k]),
            .lvl_q     (wave_lvl[k])
        );
    end
endmodule

// File: rtl/stg_checker.sv
`timescale 1ns/1ps
module stg_checker #(
    parameter int NCNT = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run_en,
    input logic [NCNT-1:0] pulse_o,
    input logic [NCNT-1:0] wave_o,
    input logic [NCNT-1:0] pol_act
);
    // R9: an edge taken with the enable low leaves every pulse low
    a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (pulse_o == '0));

    // R9: the start edge itself produces no pulse
    a_r9_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && !$past(run_en, 2)) |-> (pulse_o == '0));

    // R7: while idle each output shows only its polarity bit
    a_r7_idle_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_en) |-> (wave_o == pol_act));

    // R8: active polarity is frozen except at a start edge
    a_r8_active_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run_en) && $past(run_en, 2)) |-> $stable(pol_act));
endmodule

bind sync_timing_array stg_checker #(.NCNT(NCNT)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .pulse_o (pulse_o),
    .wave_o  (wave_o),
    .pol_act (pol_act)
);

// File: tb/sync_timing_array_test.sv
`timescale 1ns/1ps
module sync_timing_array_test;
    localparam int NC = 8;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NC-1:0] pulse_o, wave_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sync_timing_array #(.NCNT(NC)) uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pulse_o(pulse_o), .wave_o(wave_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    // R10 layouts
    function automatic logic [31:0] w0(int rl, int ol, int rs, int os);
        return {4'(os), 4'(rs), 12'(ol), 12'(rl)};
    endfunction
    function automatic logic [31:0] w1(int rep, int clr, int trig, int wen);
        return {11'd0, 1'(wen), 4'(trig), 4'(clr), 12'(rep)};
    endfunction
    function automatic logic [31:0] w2(int up, int dn);
        return {6'd0, 10'(dn), 6'd0, 10'(up)};
    endfunction

    task automatic wr(input int k, input int sel, input logic [31:0] d);
        cfg_we = 1'b1;
        cfg_addr = {1'b0, 3'(k), 2'(sel)};
        cfg_wdata = d;
        step;
        cfg_we = 1'b0;
    endtask

    task automatic wr_pol(input logic [7:0] p);
        cfg_we = 1'b1;
        cfg_addr = 6'b100000;
        cfg_wdata = {24'd0, p};
        step;
        cfg_we = 1'b0;
    endtask

    task automatic set_chan(int k, int rl, int ol, int rs, int os, int rep, int clr,
                            int trig, int wen, int up, int dn);
        wr(k, 0, w0(rl, ol, rs, os));
        wr(k, 1, w1(rep, clr, trig, wen));
        wr(k, 2, w2(up, dn));
    endtask

    task automatic zero_chans;
        for (int k = 0; k < NC; k++) set_chan(k, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic go;
        run_en = 1'b1;
        step;
    endtask

    task automatic halt;
        run_en = 1'b0;
        step;
    endtask

    // R1 R3 R4 expected pulse for a pixel-clocked counter at sample m
    function automatic bit exp_pulse(int m, int n, int r, int rep);
        if (m < n + 1) return 1'b0;
        if ((m - n - 1) % (r + 1) != 0) return 1'b0;
        if (rep != 0 && (m - n - 1) / (r + 1) >= rep) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n, r, rep, up, dn, up_h, dn_h, t, bad_p, bad_w, cnt;
        bit ep, lvl, hi, ex;
        void'($urandom(32'd4242));

        repeat (3) step;
        rst_n = 1'b1;
        step;
        chk(pulse_o == '0, "R9 reset pulses", int'(pulse_o), 0);
        chk(wave_o == '0, "R9 reset waves", int'(wave_o), 0);

        // R9: configured but not enabled
        set_chan(0, 0, 0, 1, 1, 0, 0, 1, 1, 0, 2);
        repeat (5) step;
        chk(pulse_o == '0 && wave_o == '0, "R9 idle before enable", int'(pulse_o), 0);

        // random single-counter trials: R1 R3 R4 R6
        for (int trial = 0; trial < 20; trial++) begin
            n = int'($urandom % 6); r = int'($urandom % 6); rep = int'($urandom % 4);
            up = int'($urandom % 10); dn = int'($urandom % 14);
            up_h = (up + 1) / 2; dn_h = (dn + 1) / 2;
            set_chan(0, r, n, 1, 1, rep, 0, 1, 1, up, dn);
            go;
            bad_p = 0; bad_w = 0; t = -1; lvl = 1'b0;
            for (int m = 1; m <= 48; m++) begin
                step;
                ep = exp_pulse(m, n, r, rep);
                if (ep) begin
                    t = 0;
                    if (up_h == 0) lvl = 1'b1;
                    else if (dn_h == 0) lvl = 1'b0;
                end else if (t >= 0) begin
                    t++;
                    if (t == up_h) lvl = 1'b1;
                    else if (t == dn_h) lvl = 1'b0;
                end
                if (pulse_o[0] != ep) bad_p++;
                if (wave_o[0] != lvl) bad_w++;
            end
            chk(bad_p == 0, "R1 R3 R4 random trial pulse mismatches", bad_p, 0);
            chk(bad_w == 0, "R6 random trial wave mismatches", bad_w, 0);
            halt;
        end

        // R2: chained source and source code 0
        zero_chans;
        set_chan(0, 3, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        set_chan(1, 1, 0, 2, 1, 0, 0, 0, 0, 0, 0);
        set_chan(2, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
        go;
        for (int m = 1; m <= 40; m++) begin
            step;
            ex = (m >= 2) && ((m - 2) % 8 == 0);
            chk(pulse_o[1] == ex, "R2 chained counter pulse", int'(pulse_o[1]), int'(ex));
            chk(pulse_o[2] == 1'b0, "R2 source none stays silent", int'(pulse_o[2]), 0);
        end
        halt;

        // R5: clear restarts and wins over a run tick
        zero_chans;
        set_chan(0, 9, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        set_chan(1, 0, 0, 1, 1, 2, 2, 0, 0, 0, 0);
        go;
        for (int m = 1; m <= 30; m++) begin
            step;
            ex = (m == 1) || (m >= 3 && ((m - 3) % 10 == 0 || (m - 4) % 10 == 0));
            chk(pulse_o[1] == ex, "R5 cleared counter pulse", int'(pulse_o[1]), int'(ex));
        end
        halt;

        // R6 R7: odd down position rounds up, polarity invert
        zero_chans;
        set_chan(0, 7, 0, 1, 1, 0, 0, 1, 1, 0, 7);
        wr_pol(8'h03);
        go;
        for (int m = 1; m <= 24; m++) begin
            step;
            hi = ((m - 1) % 8) < 4;
            chk(wave_o[0] == !hi, "R6 R7 inverted sync wave", int'(wave_o[0]), int'(!hi));
            chk(wave_o[1] == 1'b1, "R7 disabled inverted output", int'(wave_o[1]), 1);
        end
        halt;
        chk(wave_o[1:0] == 2'b11, "R7 idle shows polarity", int'(wave_o[1:0]), 3);
        // R8: polarity write while idle waits for the next start
        wr_pol(8'h00);
        step;
        chk(wave_o[1:0] == 2'b11, "R8 polarity held until start", int'(wave_o[1:0]), 3);
        go;
        halt;
        chk(wave_o[1:0] == 2'b00, "R8 polarity applied at start", int'(wave_o[1:0]), 0);

        // R8: run length change during a run is deferred
        zero_chans;
        set_chan(0, 4, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        go;
        for (int m = 1; m <= 20; m++) begin
            if (m == 4) begin
                cfg_we = 1'b1; cfg_addr = 6'b000000; cfg_wdata = w0(1, 0, 1, 1);
            end
            step;
            cfg_we = 1'b0;
            ex = (m - 1) % 5 == 0;
            chk(pulse_o[0] == ex, "R8 old period kept while running", int'(pulse_o[0]), int'(ex));
        end
        halt;
        go;
        for (int m = 1; m <= 10; m++) begin
            step;
            ex = (m - 1) % 2 == 0;
            chk(pulse_o[0] == ex, "R8 new period after restart", int'(pulse_o[0]), int'(ex));
        end
        halt;

        // R4: repeat limit with an offset
        set_chan(0, 2, 1, 1, 1, 3, 0, 0, 0, 0, 0);
        go;
        cnt = 0;
        for (int m = 1; m <= 40; m++) begin
            step;
            if (pulse_o[0]) cnt++;
        end
        chk(cnt == 3, "R4 repeat count of three", cnt, 3);
        halt;

        // R9: dropping the enable silences everything
        set_chan(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
        go;
        step;
        chk(pulse_o[0] == 1'b1, "R1 free run pulses every clock", int'(pulse_o[0]), 1);
        halt;
        cnt = 0;
        for (int m = 0; m < 5; m++) begin
            if (pulse_o != '0) cnt++;
            step;
        end
        chk(cnt == 0, "R9 no pulses after disable", cnt, 0);

        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule